// File: doc/BRIEF.md
# Packed Halfword Saturating ALU

This block performs one of seven arithmetic operations on two 64-bit operands, each handled as four independent 16-bit lanes. The operations are signed-saturating add and subtract, mixed-sign unsigned-saturating add and subtract, a rounding average, and two shift-then-add forms. The two shift-then-add forms scale the first operand by a 2-bit shift amount before the sum is clamped. It sits in an execution pipeline behind operand fetch. A valid strobe qualifies each operation, and the packed result comes out of a single output register one clock later.

Each lane widens both halves to an internal width large enough that no intermediate value wraps. It computes the exact result and clamps it to the range of the operation. The result lands back in the lane position it came from. The average does not saturate. It halves the 17-bit sum and keeps the dropped low bit by OR-ing it into the result.

Top module: `lane_sat_alu`

## Requirements
- R1: Lane k (k = 0..3) of the result occupies bits [16k+15:16k] and depends only on bits [16k+15:16k] of `src_a` and `src_b`.
- R2: With `op_sel` = 0 each lane is the signed sum of the two lanes, clamped to -32768..32767.
- R3: With `op_sel` = 1 each lane is `src_a` lane read unsigned plus `src_b` lane read signed, clamped to 0..65535.
- R4: With `op_sel` = 2 each lane is s >> 1 OR (s & 1), where s is the 17-bit sum of both lanes read unsigned.
- R5: With `op_sel` = 3 each lane is the signed difference a - b, clamped to -32768..32767.
- R6: With `op_sel` = 4 each lane is `src_a` lane read unsigned minus `src_b` lane read signed, clamped to 0..65535.
- R7: With `op_sel` = 5 each lane is (signed a shifted left by `shamt`) + signed b, clamped to the signed 16-bit range, with no wrap before the clamp.
- R8: With `op_sel` = 6 each lane is (signed a arithmetically shifted right by `shamt`) + signed b, clamped to the signed 16-bit range.
- R9: With `op_sel` 5 or 6 and `shamt` = 0 the result equals that of `op_sel` = 0.
- R10: `op_sel` = 7 yields an all-zero result.
- R11: `out_valid` equals the `in_valid` sampled at the previous rising edge, and `out_data` holds the result of the operands sampled at that edge.
- R12: In a cycle with `in_valid` low, `out_data` keeps its previous value.
- R13: While reset is asserted, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies the operands and operation this cycle |
| op_sel | input | 3 | Operation code (0..7, see R2-R10) |
| shamt | input | 2 | Shift amount for the shift-then-add forms |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Packed result |

## Verification
Every result is due exactly one rising edge after its operands are sampled. Nothing else lies between the inputs and `out_data`, because the lane arithmetic is combinational ahead of the single output register. The bench keeps its expected valid flag and expected word in variables that it updates at that same edge from the operands it drove. It compares them with the outputs at the following falling edge, so every comparison looks at one settled cycle. Cycles with `in_valid` low are also compared against the unchanged expectation, which covers the hold behaviour cycle by cycle.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [2:0] {
    OP_SADD   = 3'd0,
    OP_UADD   = 3'd1,
    OP_AVG    = 3'd2,
    OP_SSUB   = 3'd3,
    OP_USUB   = 3'd4,
    OP_SHLADD = 3'd5,
    OP_SHRADD = 3'd6,
    OP_NONE   = 3'd7
  } alu_op_e;

endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/lane_sat_clamp.sv
module lane_sat_clamp #(
  parameter int LANE_W = 16,
  parameter int EXT_W  = 20
) (
  input  logic signed [EXT_W-1:0]  val,
  input  logic                     uns,
  output logic        [LANE_W-1:0] sat
);

  localparam logic signed [EXT_W-1:0] S_MAX = EXT_W'((64'd1 << (LANE_W-1)) - 64'd1);
  localparam logic signed [EXT_W-1:0] S_MIN = ~S_MAX;
  localparam logic signed [EXT_W-1:0] U_MAX = EXT_W'((64'd1 << LANE_W) - 64'd1);
  localparam logic signed [EXT_W-1:0] U_MIN = '0;

  logic [LANE_W-1:0] s_res;
  logic [LANE_W-1:0] u_res;

  always_comb begin
    if (val > S_MAX) begin
      s_res = S_MAX[LANE_W-1:0];
    end else if (val < S_MIN) begin
      s_res = S_MIN[LANE_W-1:0];
    end else begin
      s_res = val[LANE_W-1:0];
    end

    if (val > U_MAX) begin
      u_res = U_MAX[LANE_W-1:0];
    end else if (val < U_MIN) begin
      u_res = U_MIN[LANE_W-1:0];
    end else begin
      u_res = val[LANE_W-1:0];
    end

    sat = uns ? u_res : s_res;
  end

endmodule

// File: rtl/lane_core.sv
module lane_core
  import lane_alu_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SH_W   = 2,
  parameter int EXT_W  = 20
) (
  input  alu_op_e            op,
  input  logic [SH_W-1:0]    sh,
  input  logic [LANE_W-1:0]  a,
  input  logic [LANE_W-1:0]  b,
  output logic [LANE_W-1:0]  res
);

  localparam int PAD_W = EXT_W - LANE_W;

  logic signed [EXT_W-1:0] a_s;
  logic signed [EXT_W-1:0] a_u;
  logic signed [EXT_W-1:0] b_s;
  logic signed [EXT_W-1:0] b_u;
  logic signed [EXT_W-1:0] wide;
  logic                    uns_clamp;
  logic        [LANE_W:0]  avg_sum;
  logic        [LANE_W-1:0] avg_res;
  logic        [LANE_W-1:0] clamped;

  always_comb begin
    a_s = {{PAD_W{a[LANE_W-1]}}, a};
    a_u = {{PAD_W{1'b0}}, a};
    b_s = {{PAD_W{b[LANE_W-1]}}, b};
    b_u = {{PAD_W{1'b0}}, b};

    avg_sum = {1'b0, a} + {1'b0, b};
    avg_res = avg_sum[LANE_W:1] | {{(LANE_W-1){1'b0}}, avg_sum[0]};

    wide      = '0;
    uns_clamp = 1'b0;
    case (op)
      OP_SADD:   wide = a_s + b_s;
      OP_UADD: begin
        wide      = a_u + b_s;
        uns_clamp = 1'b1;
      end
      OP_SSUB:   wide = a_s - b_s;
      OP_USUB: begin
        wide      = a_u - b_s;
        uns_clamp = 1'b1;
      end
      OP_SHLADD: wide = (a_s <<< sh) + b_s;
      OP_SHRADD: wide = (a_s >>> sh) + b_s;
      default:   wide = b_u - b_u;
    endcase
  end

  lane_sat_clamp #(
    .LANE_W (LANE_W),
    .EXT_W  (EXT_W)
  ) u_clamp (
    .val (wide),
    .uns (uns_clamp),
    .sat (clamped)
  );

  always_comb begin
    case (op)
      OP_AVG:  res = avg_res;
      OP_NONE: res = '0;
      default: res = clamped;
    endcase
  end

endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] res_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  if (OUT_REG) begin : g_reg
    logic              vld_d;
    logic              vld_q;
    logic [DATA_W-1:0] data_d;
    logic [DATA_W-1:0] data_q;
    logic              data_en;

    always_comb begin
      data_en = in_valid;
      vld_d   = in_valid;
      data_d  = data_en ? res_in : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        vld_q  <= vld_d;
        data_q <= data_d;
      end
    end

    assign out_valid = vld_q;
    assign out_data  = data_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = res_in;
  end

endmodule

// File: rtl/lane_sat_alu.sv
module lane_sat_alu
  import lane_alu_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 4,
  parameter int SH_W    = 2,
  parameter int OP_W    = 3,
  parameter bit OUT_REG = 1'b1,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int EXT_W = LANE_W + (1 << SH_W);

  alu_op_e           op_e;
  logic              rst_int_n;
  logic [DATA_W-1:0] packed_res;

  assign op_e = alu_op_e'(op_sel);

  lane_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_core #(
      .LANE_W (LANE_W),
      .SH_W   (SH_W),
      .EXT_W  (EXT_W)
    ) u_lane (
      .op  (op_e),
      .sh  (shamt),
      .a   (src_a[k*LANE_W +: LANE_W]),
      .b   (src_b[k*LANE_W +: LANE_W]),
      .res (packed_res[k*LANE_W +: LANE_W])
    );
  end

  lane_out_stage #(
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .res_in    (packed_res),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/lane_sat_alu_chk.sv
module lane_sat_alu_chk #(
  parameter int DATA_W  = 64,
  parameter int OP_W    = 3,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  if (OUT_REG) begin : g_chk
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R12
    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd7) |=> (out_data == '0)); // R10
    AST_SADD_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd0 && !src_a[15] && !src_b[15]) |=> !out_data[15]); // R2
    AST_AVG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd2 && src_a[15] && src_b[15]) |=> out_data[15]); // R4
    AST_UADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd1 && !src_b[15]) |=> (out_data[15:0] >= $past(src_a[15:0]))); // R3
    AST_USUB_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd4 && !src_b[15]) |=> (out_data[15:0] <= $past(src_a[15:0]))); // R6
  end

endmodule

bind lane_sat_alu lane_sat_alu_chk #(
  .DATA_W  (DATA_W),
  .OP_W    (OP_W),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/lane_sat_alu_tb_top.sv
module lane_sat_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  shamt = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    model_on = 1'b0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R2";
  string exp_tag = "R2";
  logic        exp_valid = 1'b0;
  logic [63:0] exp_data = '0;

  always #5 clk = ~clk;

  lane_sat_alu dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .shamt     (shamt),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic int sclamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int uclamp(int v);
    if (v > 65535) return 65535;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic logic [15:0] ref_lane(int op, int sh, logic [15:0] a, logic [15:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    int ua = int'(a);
    int ub = int'(b);
    int r;
    case (op)
      0: r = sclamp(sa + sb);
      1: r = uclamp(ua + sb);
      2: r = ((ua + ub) >> 1) | ((ua + ub) & 1);
      3: r = sclamp(sa - sb);
      4: r = uclamp(ua - sb);
      5: r = sclamp(sa * (1 << sh) + sb);
      6: r = sclamp((sa >>> sh) + sb);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_word(int op, int sh, logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) begin
      w[k*16 +: 16] = ref_lane(op, sh, a[k*16 +: 16], b[k*16 +: 16]);
    end
    return w;
  endfunction

  function automatic string op_tag(int op, int sh);
    if ((op == 5 || op == 6) && sh == 0) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] pick_lane();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: one register stage, updated at the same edge as the design
  always @(posedge clk) begin
    chk_on <= model_on;
    if (model_on) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_data <= ref_word(int'(op_sel), int'(shamt), src_a, src_b);
        exp_tag  <= cur_tag;
      end else begin
        exp_tag  <= "R12";
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check_eq("R11", {63'b0, out_valid}, {63'b0, exp_valid});
      check_eq(exp_tag, out_data, exp_data);
    end
  end

  task automatic drive(logic v, int op, int sh, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    in_valid = v;
    op_sel   = 3'(op);
    shamt    = 2'(sh);
    src_a    = a;
    src_b    = b;
    cur_tag  = tag;
  endtask

  task automatic drive_op(int op, int sh, logic [63:0] a, logic [63:0] b);
    drive(1'b1, op, sh, a, b, op_tag(op, sh));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: outputs cleared during reset
    check_eq("R13", {63'b0, out_valid}, 64'd0);
    check_eq("R13", out_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;
    @(negedge clk);

    // R2 R5 signed boundaries
    drive_op(0, 0, 64'h8000_FFFF_0001_7FFF, 64'hFFFF_8000_0001_0001);
    drive_op(3, 0, 64'h7FFF_0000_0005_8000, 64'hFFFF_8000_0007_0001);
    // R3 R6 mixed-sign unsigned boundaries
    drive_op(1, 0, 64'h8000_1234_0000_FFFF, 64'h8000_0010_FFFF_0001);
    drive_op(4, 0, 64'h0010_1234_FFFF_0000, 64'h0011_FFFF_FFFF_0001);
    // R4 average with rounding bit
    drive_op(2, 0, 64'hFFFF_0000_0004_0001, 64'hFFFF_0001_0003_0002);
    // R7 shift-left overflow that would wrap in 16 bits
    drive_op(5, 3, 64'hF000_8000_0100_1000, 64'h0000_0000_0001_0000);
    drive_op(5, 1, 64'h4000_C000_0003_3FFF, 64'h0000_FFFF_0002_0001);
    // R8 arithmetic right shift of negative values
    drive_op(6, 2, 64'h8000_FFFF_0007_FFFC, 64'h8000_0000_0001_0000);
    drive_op(6, 3, 64'h7FFF_8000_0010_0000, 64'h7FFF_FFFF_0001_0000);
    // R9 zero shift
    drive_op(5, 0, 64'h7FFF_8000_1234_0001, 64'h0001_FFFF_4321_0001);
    drive_op(6, 0, 64'h7FFF_8000_1234_0001, 64'h0001_FFFF_4321_0001);
    // R10 unused code
    drive_op(7, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    // R12 idle cycles hold the last result, even with changing operands
    drive_op(0, 0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
    drive(1'b0, 1, 1, 64'hAAAA_5555_AAAA_5555, 64'h5555_AAAA_5555_AAAA, "R12");
    drive(1'b0, 3, 2, 64'h1111_2222_3333_4444, 64'h0, "R12");
    // R1 lanes mixing saturating and non-saturating values
    drive(1'b1, 0, 0, 64'h7FFF_0001_8000_1234, 64'h0001_0001_FFFF_0000, "R1");
    drive(1'b1, 4, 0, 64'h0000_FFFF_8000_0001, 64'h0001_FFFF_0001_7FFF, "R1");

    // random stimulus over all codes with biased lane values
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] ra, rb;
      int op, sh;
      for (int k = 0; k < 4; k++) begin
        ra[k*16 +: 16] = pick_lane();
        rb[k*16 +: 16] = pick_lane();
      end
      op = int'($urandom % 8);
      sh = int'($urandom % 4);
      if (($urandom % 5) == 0) drive(1'b0, op, sh, ra, rb, "R12");
      else drive_op(op, sh, ra, rb);
    end
    drive(1'b0, 0, 0, 64'h0, 64'h0, "R12");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule